// File: doc/BRIEF.md
# Receive Test-Pattern Synchronizer and Error Checker

This block checks a received serial bit stream against a locally generated copy of a test pattern. The pattern is either a pseudo-random sequence or a repeating word. The local generator has the same programmable structure as a transmit-side generator: a shift register whose length `n` and tap position `y` are configurable. The checker first seeds that register from the line and then lets it run free. It declares lock once the prediction has matched a run of consecutive bits, and from then on it reports every bit that differs.

While locked, a 64-bit window monitor watches the mismatch density. If six or more mismatches fall inside one window, the checker drops lock and reseeds, unless automatic resync is disabled. Software can also force a reseed with a rising edge on a request input. An optional inversion stage flips the incoming stream before any comparison, which allows inverted test signals to be checked. Two saturating counters accumulate checked bits and errored bits while the checker is locked.

Top module: `rx_pattern_checker`

## Requirements
- R1: When `inv_en` is 1, each received bit is inverted before it enters the checker (seeding and comparison alike); when it is 0, the bit is used unchanged.
- R2: In pseudo-random mode (`cfg_repeat` = 0), with n = `cfg_len`+1 and y = `cfg_tap`+1, the expected bit is the XOR of the bit received n bits earlier and the bit received y bits earlier in the reference register.
- R3: In repeat mode (`cfg_repeat` = 1), the expected bit equals the bit n positions back, so an n-bit word recirculates and `cfg_tap` has no effect.
- R4: After a reseed, the first n valid bits are loaded as the seed, and the following 32 valid bits are compared. `in_sync` rises at the clock edge that takes the 32nd consecutive matching bit. A mismatch among those 32 bits restarts seeding.
- R5: A 0-to-1 change of `man_resync` drops `in_sync` at the next clock edge and restarts seeding, and the valid bit present in that cycle is discarded. Holding `man_resync` at 1 starts no further reseed.
- R6: While locked, the valid bits are split into 64-bit windows, the first starting at lock. A sixth mismatch within one window (with `auto_dis` = 0) drops `in_sync` at that bit's edge and restarts seeding. Mismatches do not carry across a window boundary.
- R7: With `auto_dis` = 1, mismatches never drop `in_sync`.
- R8: `bit_err` is high for the one cycle after each valid bit that mismatched while locked, and stays low for mismatches while not locked.
- R9: `bit_count` and `err_count` increment only for valid bits taken while locked (`err_count` only on mismatches), and saturate at all ones.
- R10: After reset, `in_sync`, `bit_err`, `bit_count` and `err_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received serial data bit |
| rx_valid | input | 1 | Qualifies `rx_bit` in this cycle |
| cfg_repeat | input | 1 | 0 = pseudo-random pattern, 1 = repeating word |
| cfg_len | input | 5 | Register length minus one (n-1) |
| cfg_tap | input | 5 | Tap position minus one (y-1), pseudo-random mode only |
| inv_en | input | 1 | Invert received bits before checking |
| man_resync | input | 1 | Rising edge forces a reseed |
| auto_dis | input | 1 | 1 = never drop lock on errors |
| in_sync | output | 1 | Checker locked to the stream |
| bit_err | output | 1 | One-cycle pulse per mismatched bit while locked |
| bit_count | output | 32 | Saturating count of bits checked while locked |
| err_count | output | 32 | Saturating count of mismatches while locked |

## Verification
All outputs are registered on the edge that takes a valid bit, so `in_sync`, `bit_err` and both counters reflect bit k directly after the k-th valid rising edge. A manual request is visible on `in_sync` one edge after `man_resync` rises. The bench drives inputs on the falling edge and samples 2 ns after the rising edge that consumed the bit. Expected lock points therefore come from counting bits: n seed bits plus 32 verify bits. Window positions are counted from the bit after lock.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  typedef enum logic [1:0] {
    ST_SEED   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCK   = 2'd2
  } rpc_state_e;
endpackage

// File: rtl/rpc_ref_gen.sv
// Local reference generator: seeded from the line, then free-running.
module rpc_ref_gen #(
  parameter int W = 32,
  localparam int SEL_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             take_rx,
  input  logic             rx_d,
  input  logic             rep_mode,
  input  logic [SEL_W-1:0] len_sel,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             pred
);
  logic [W-1:0] sr_q, sr_d;
  logic         fb_len, fb_tap;

  always_comb begin
    fb_len = sr_q[len_sel];
    fb_tap = rep_mode ? 1'b0 : sr_q[tap_sel];
    pred   = fb_len ^ fb_tap;
    sr_d   = sr_q;
    if (step) sr_d = {sr_q[W-2:0], (take_rx ? rx_d : pred)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/rpc_win_mon.sv
// Mismatch density monitor over fixed windows of valid locked bits.
module rpc_win_mon #(
  parameter int WIN   = 64,
  parameter int LIMIT = 6,
  localparam int WIN_W  = $clog2(WIN),
  localparam int MISS_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic miss,
  output logic trip
);
  logic [WIN_W-1:0]  win_q, win_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              last;

  always_comb begin
    last   = (win_q == WIN_W'(WIN - 1));
    trip   = step && miss && ((32'(miss_q) + 32'd1) >= 32'(LIMIT));
    win_d  = win_q;
    miss_d = miss_q;
    if (clr) begin
      win_d  = '0;
      miss_d = '0;
    end else if (step) begin
      win_d = last ? '0 : win_q + WIN_W'(1);
      if (last)                                miss_d = '0;
      else if (miss && 32'(miss_q) < LIMIT)    miss_d = miss_q + MISS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      miss_q <= '0;
    end else begin
      win_q  <= win_d;
      miss_q <= miss_d;
    end
  end
endmodule

// File: rtl/rpc_sat_cnt.sv
module rpc_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (inc && !(&cnt)) cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/rx_pattern_checker.sv
module rx_pattern_checker
  import rpc_pkg::*;
#(
  parameter int MAX_LEN   = 32,
  parameter int SYNC_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int ERR_LIMIT = 6,
  parameter int CNT_W     = 32,
  localparam int SEL_W = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic             rx_valid,
  input  logic             cfg_repeat,
  input  logic [SEL_W-1:0] cfg_len,
  input  logic [SEL_W-1:0] cfg_tap,
  input  logic             inv_en,
  input  logic             man_resync,
  input  logic             auto_dis,
  output logic             in_sync,
  output logic             bit_err,
  output logic [CNT_W-1:0] bit_count,
  output logic [CNT_W-1:0] err_count
);
  localparam int RUN_MAX = (MAX_LEN > SYNC_RUN) ? MAX_LEN : SYNC_RUN;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  rpc_state_e       st_q, st_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             man_q;
  logic             err_q, err_d;
  logic             d_in, man_edge, pred, miss, take, lock_step, trip;

  assign d_in      = rx_bit ^ inv_en;
  assign man_edge  = man_resync & ~man_q;
  assign miss      = d_in ^ pred;
  assign take      = rx_valid && !man_edge;
  assign lock_step = take && (st_q == ST_LOCK);

  rpc_ref_gen #(.W(MAX_LEN)) u_gen (
    .clk(clk), .rst_n(rst_n), .step(take), .take_rx(st_q == ST_SEED),
    .rx_d(d_in), .rep_mode(cfg_repeat), .len_sel(cfg_len),
    .tap_sel(cfg_tap), .pred(pred)
  );

  rpc_win_mon #(.WIN(WIN_LEN), .LIMIT(ERR_LIMIT)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(st_q != ST_LOCK), .step(lock_step),
    .miss(miss), .trip(trip)
  );

  rpc_sat_cnt #(.W(CNT_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .inc(lock_step), .cnt(bit_count)
  );

  rpc_sat_cnt #(.W(CNT_W)) u_errs (
    .clk(clk), .rst_n(rst_n), .inc(lock_step && miss), .cnt(err_count)
  );

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    run_d = run_q;
    err_d = lock_step && miss;
    if (man_edge) begin
      st_d  = ST_SEED;
      run_d = '0;
    end else if (rx_valid) begin
      unique case (st_q)
        ST_SEED: begin
          if (run_q == RUN_W'(cfg_len)) begin
            st_d  = ST_VERIFY;
            run_d = '0;
          end else begin
            run_d = run_q + RUN_W'(1);
          end
        end
        ST_VERIFY: begin
          if (miss) begin
            st_d  = ST_SEED;
            run_d = '0;
          end else if (run_q == RUN_W'(SYNC_RUN - 1)) begin
            st_d  = ST_LOCK;
            run_d = '0;
          end else begin
            run_d = run_q + RUN_W'(1);
          end
        end
        ST_LOCK: begin
          if (trip && !auto_dis) begin
            st_d  = ST_SEED;
            run_d = '0;
          end
        end
        default: begin
          st_d  = ST_SEED;
          run_d = '0;
        end
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SEED;
      run_q <= '0;
      man_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
      man_q <= man_resync;
      err_q <= err_d;
    end
  end

  assign in_sync = (st_q == ST_LOCK);
  assign bit_err = err_q;
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             man_resync,
  input logic             auto_dis,
  input logic             in_sync,
  input logic             bit_err,
  input logic [CNT_W-1:0] bit_count,
  input logic [CNT_W-1:0] err_count
);
  p_manual_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (man_resync && !$past(man_resync)) |=> !in_sync);

  p_hold_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && auto_dis && !(man_resync && !$past(man_resync))) |=> in_sync);

  p_err_when_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> ($past(in_sync) && $past(rx_valid)));

  p_err_counted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> ((err_count == $past(err_count) + CNT_W'(1)) || (&err_count)));

  p_bits_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sync |=> (bit_count == $past(bit_count)));

  p_errs_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count >= $past(err_count)));
endmodule

bind rx_pattern_checker rpc_checker #(.CNT_W(CNT_W)) u_rpc_checker (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .man_resync(man_resync),
  .auto_dis(auto_dis), .in_sync(in_sync), .bit_err(bit_err),
  .bit_count(bit_count), .err_count(err_count)
);

// File: tb/test_rx_pattern_checker.sv
module test_rx_pattern_checker;
  typedef struct packed {
    logic       rep;
    logic [4:0] len;
    logic [4:0] tap;
    logic       inv;
    logic [7:0] nbits;
    logic [7:0] errpos;
    logic       exp_sync;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 5'd6,  5'd5,  1'b0, 8'd38, 8'd0,  1'b0}, // R4 one bit short
    '{1'b0, 5'd6,  5'd5,  1'b0, 8'd39, 8'd0,  1'b1}, // R2 R4 n=7 y=6
    '{1'b0, 5'd14, 5'd13, 1'b0, 8'd47, 8'd0,  1'b1}, // R2 n=15 y=14
    '{1'b0, 5'd14, 5'd13, 1'b0, 8'd46, 8'd0,  1'b0}, // R4 one bit short
    '{1'b0, 5'd6,  5'd5,  1'b1, 8'd39, 8'd0,  1'b1}, // R1 inverted line
    '{1'b1, 5'd7,  5'd3,  1'b0, 8'd40, 8'd0,  1'b1}, // R3 tap ignored
    '{1'b1, 5'd7,  5'd0,  1'b0, 8'd40, 8'd0,  1'b1}, // R3 word of 8
    '{1'b0, 5'd6,  5'd5,  1'b0, 8'd39, 8'd20, 1'b0}, // R4 verify mismatch
    '{1'b0, 5'd4,  5'd2,  1'b0, 8'd37, 8'd0,  1'b1}, // R2 n=5 y=3
    '{1'b0, 5'd19, 5'd2,  1'b0, 8'd52, 8'd0,  1'b1}  // R2 n=20 y=3
  };
  localparam logic [63:0] SEED = 64'h5A3C_96E1_0F77_1234;

  logic        clk, rst_n, rx_bit, rx_valid, cfg_repeat, inv_en, man_resync, auto_dis;
  logic [4:0]  cfg_len, cfg_tap;
  logic        in_sync, bit_err;
  logic [31:0] bit_count, err_count, base_b, base_e;
  logic [63:0] hist;
  logic        cur_inv;
  int          total, bad;

  rx_pattern_checker i_rx_pattern_checker (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .cfg_repeat(cfg_repeat), .cfg_len(cfg_len), .cfg_tap(cfg_tap),
    .inv_en(inv_en), .man_resync(man_resync), .auto_dis(auto_dis),
    .in_sync(in_sync), .bit_err(bit_err), .bit_count(bit_count),
    .err_count(err_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Pattern source built from the requirement recurrences (R2, R3).
  task automatic next_bit(output logic b);
    b = hist[cfg_len] ^ (cfg_repeat ? 1'b0 : hist[cfg_tap]);
    hist = {hist[62:0], b};
  endtask

  task automatic send(input logic flip);
    logic b;
    next_bit(b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_bit   = b ^ cur_inv ^ flip;
    @(posedge clk);
    #2;
    rx_valid = 1'b0;
  endtask

  task automatic send_n(input int n, input logic flip);
    for (int k = 0; k < n; k++) send(flip);
  endtask

  task automatic pulse_manual();
    @(negedge clk) man_resync = 1'b1;
    @(negedge clk) man_resync = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rx_bit = 0; rx_valid = 0; cfg_repeat = 0; cfg_len = 5'd6; cfg_tap = 5'd5;
    inv_en = 0; man_resync = 0; auto_dis = 0; cur_inv = 0; hist = SEED;
    do_reset();
    #2;
    chk("R10 in_sync", 32'(in_sync), 0);
    chk("R10 bit_err", 32'(bit_err), 0);
    chk("R10 bit_count", bit_count, 0);
    chk("R10 err_count", err_count, 0);

    for (int i = 0; i < NVEC; i++) begin
      cfg_repeat = VEC[i].rep; cfg_len = VEC[i].len; cfg_tap = VEC[i].tap;
      cur_inv = VEC[i].inv; inv_en = VEC[i].inv; hist = SEED;
      pulse_manual();
      for (int k = 1; k <= int'(VEC[i].nbits); k++) send(k == int'(VEC[i].errpos));
      chk($sformatf("R4 table entry %0d", i), 32'(in_sync), 32'(VEC[i].exp_sync));
    end

    // Window and counter behaviour, n=7 y=6
    cfg_repeat = 0; cfg_len = 5'd6; cfg_tap = 5'd5; cur_inv = 0; inv_en = 0; hist = SEED;
    pulse_manual();
    send_n(39, 1'b0);
    chk("R4 lock", 32'(in_sync), 1);
    base_b = bit_count; base_e = err_count;
    send_n(10, 1'b0);
    chk("R9 bit_count", bit_count, base_b + 10);
    send(1'b1);
    chk("R8 bit_err pulse", 32'(bit_err), 1);
    send_n(4, 1'b1);
    send(1'b0);
    chk("R8 bit_err low", 32'(bit_err), 0);
    chk("R6 five kept", 32'(in_sync), 1);
    chk("R9 err_count", err_count, base_e + 5);
    send_n(48, 1'b0);
    send_n(5, 1'b1);
    chk("R6 window cleared", 32'(in_sync), 1);
    send(1'b1);
    chk("R6 sixth drops", 32'(in_sync), 0);
    chk("R9 err_count 11", err_count, base_e + 11);
    send(1'b1);
    chk("R8 no pulse unlocked", 32'(bit_err), 0);
    send_n(4, 1'b0);
    chk("R9 frozen unlocked", bit_count, base_b + 70);

    // Auto resync disabled
    pulse_manual();
    send_n(39, 1'b0);
    auto_dis = 1'b1;
    send_n(8, 1'b1);
    chk("R7 lock held", 32'(in_sync), 1);
    auto_dis = 1'b0;

    // Manual edge versus level
    @(negedge clk) man_resync = 1'b1;
    @(posedge clk); #2;
    chk("R5 edge drops", 32'(in_sync), 0);
    send_n(39, 1'b0);
    chk("R5 level no restart", 32'(in_sync), 1);
    @(negedge clk) man_resync = 1'b0;
    send_n(3, 1'b0);
    chk("R5 still locked", 32'(in_sync), 1);
    pulse_manual();
    chk("R5 second edge", 32'(in_sync), 0);

    // Reset mid-run
    do_reset();
    #2;
    chk("R10 reset count", bit_count, 0);
    chk("R10 reset sync", 32'(in_sync), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule